// File: doc/BRIEF.md
# Bus-Multiplexed Program ROM with Output Port

This block is a program-memory node on a shared 4-bit bus that is time-sliced into an eight-phase instruction cycle (A1, A2, A3, M1, M2, X1, X2, X3). A sync strobe marks the first phase of each cycle. The node collects a 12-bit fetch address one nibble per phase. It compares the top nibble with its own chip number. When it is the addressed chip, it returns the 8-bit word in two nibbles. The word store is a parameter image.

The node also reads every fetched instruction off the bus. From these it notices a chip-select instruction that names it, and it then serves port-write and port-read instructions through a 4-bit output register and a 4-bit input port. The bus has fixed slots, so there is no valid/ready handshake and no back-pressure: the node speaks only in its slots and must always be able to accept a nibble. One clock period is one bus phase.

Top module: `rom_io_node`

## Requirements
- R1: The clock with `sync_i` high is phase A1. Later clocks step through A2, A3, M1, M2, X1, X2, X3 and then wrap to A1. A sync strobe in any phase restarts the sequence at A1.
- R2: The node is selected for a fetch only when the nibble at A3 equals `CHIP_ID` and `cmd_i` is high at A3. The 8-bit word address is {nibble at A2, nibble at A1}.
- R3: When selected, the node drives bits [7:4] of the stored word at M1 and bits [3:0] at M2, with `bus_oe` high.
- R4: `bus_oe` is low in every phase except the slots given in R3 and R7. An unselected node never drives at M1 or M2.
- R5: A chip-select instruction has OPR (M1 nibble) = 4'b0010 and bit 0 of OPA (M2 nibble) set. At X2 of that cycle the node becomes the I/O target if `cmd_i` is high and the X2 nibble equals `CHIP_ID`. Otherwise it stops being the target.
- R6: The I/O group is OPR = 4'b1110 with `cmd_i` high at M2. OPA = 4'b0010 is a port write. On a port write, a targeted node loads the X2 bus nibble into `port_out` at the end of X2, and `port_out` keeps its value in every other phase.
- R7: OPA = 4'b1010 is a port read. During X2 only, a targeted node drives `port_in` onto the bus.
- R8: I/O instructions do nothing when the node is not the target, when `cmd_i` is low at M2, or when OPA is neither code.
- R9: `port_clr_n` low clears `port_out` at once without a clock, and it overrides a port write in the same phase.
- R10: `rst_n` low at a clock edge clears the phase to A1, the selection, the target flag, the decoded instruction and `port_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Phase clock, one period per bus phase |
| rst_n | input | 1 | Synchronous reset, active low |
| sync_i | input | 1 | Marks phase A1 of an instruction cycle |
| cmd_i | input | 1 | Command line: bank enable at A3, I/O flag at M2, select flag at X2 |
| bus_i | input | 4 | Resolved value of the shared bus |
| bus_o | output | 4 | Nibble this node drives |
| bus_oe | output | 1 | Drive enable for `bus_o`; the node floats when low |
| port_in | input | 4 | External port input lines |
| port_out | output | 4 | Port output register |
| port_clr_n | input | 1 | Asynchronous clear of `port_out`, active low |

## Verification
Two functions share phase X2: a port write loading `port_out`, and the asynchronous clear. The bench holds the clear low across the X2 clock edge of a targeted port write. `port_out` must read zero before that edge, stay zero after it, and keep the old register value in no phase. A second clash comes from a sync strobe that cuts a cycle short. The bench restarts the cycle at M1 and then checks that the next full fetch returns the correct word. Every phase is compared against a behavioural model that resolves the shared bus the way a real bus would.

// File: rtl/rom_io_pkg.sv
package rom_io_pkg;
  localparam int NIB_W     = 4;
  localparam int ROM_AW    = 8;
  localparam int ROM_DEPTH = 1 << ROM_AW;
  localparam int WORD_W    = 2 * NIB_W;

  typedef enum logic [2:0] {
    PH_A1, PH_A2, PH_A3, PH_M1, PH_M2, PH_X1, PH_X2, PH_X3
  } phase_t;

  localparam logic [NIB_W-1:0] OPR_IO   = 4'b1110;
  localparam logic [NIB_W-1:0] OPR_SEL  = 4'b0010;
  localparam logic [NIB_W-1:0] OPA_PWR  = 4'b0010;
  localparam logic [NIB_W-1:0] OPA_PRD  = 4'b1010;

  // Default word image: word i = (i*37) xor 0xA5, low 8 bits.
  function automatic logic [ROM_DEPTH*WORD_W-1:0] default_image();
    logic [ROM_DEPTH*WORD_W-1:0] img;
    for (int i = 0; i < ROM_DEPTH; i++)
      img[i*WORD_W +: WORD_W] = WORD_W'((i * 37) ^ 165);
    return img;
  endfunction
endpackage

// File: rtl/rom_phase_track.sv
module rom_phase_track
  import rom_io_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   sync_i,
  output phase_t ph_now
);
  phase_t ph_q;

  assign ph_now = sync_i ? PH_A1 : ph_q;

  always_ff @(posedge clk) begin
    if (!rst_n) ph_q <= PH_A1;
    else        ph_q <= phase_t'(ph_now + 3'd1);
  end
endmodule

// File: rtl/rom_fetch_ctl.sv
module rom_fetch_ctl
  import rom_io_pkg::*;
#(
  parameter logic [NIB_W-1:0] CHIP_ID = 4'd0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  phase_t            ph_now,
  input  logic              cmd_i,
  input  logic [NIB_W-1:0]  bus_i,
  output logic [ROM_AW-1:0] word_addr,
  output logic              sel_q
);
  logic [NIB_W-1:0] lo_q, mid_q;

  assign word_addr = {mid_q, lo_q};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lo_q  <= '0;
      mid_q <= '0;
      sel_q <= 1'b0;
    end else begin
      unique case (ph_now)
        PH_A1:   lo_q  <= bus_i;
        PH_A2:   mid_q <= bus_i;
        PH_A3:   sel_q <= cmd_i && (bus_i == CHIP_ID);
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/rom_word_store.sv
module rom_word_store
  import rom_io_pkg::*;
#(
  parameter logic [ROM_DEPTH*WORD_W-1:0] IMAGE = default_image()
) (
  input  logic [ROM_AW-1:0] addr,
  input  logic              upper,
  output logic [NIB_W-1:0]  nib
);
  localparam int IDX_W = ROM_AW + $clog2(WORD_W);
  logic [WORD_W-1:0] word;
  logic [IDX_W-1:0]  base;

  assign base = {addr, {$clog2(WORD_W){1'b0}}};
  assign word = IMAGE[base +: WORD_W];
  assign nib  = upper ? word[WORD_W-1 -: NIB_W] : word[NIB_W-1:0];
endmodule

// File: rtl/rom_io_port.sv
module rom_io_port
  import rom_io_pkg::*;
#(
  parameter logic [NIB_W-1:0] CHIP_ID = 4'd0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_n,
  input  phase_t           ph_now,
  input  logic             cmd_i,
  input  logic [NIB_W-1:0] bus_i,
  output logic [NIB_W-1:0] port_q,
  output logic             rd_drive
);
  logic [NIB_W-1:0] opr_q, opa_q;
  logic             sel_instr_q, io_instr_q, target_q;
  logic             wr_hit;

  assign rd_drive = (ph_now == PH_X2) && io_instr_q && target_q && (opa_q == OPA_PRD);
  assign wr_hit   = (ph_now == PH_X2) && io_instr_q && target_q && (opa_q == OPA_PWR);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      opr_q       <= '0;
      opa_q       <= '0;
      sel_instr_q <= 1'b0;
      io_instr_q  <= 1'b0;
      target_q    <= 1'b0;
    end else begin
      unique case (ph_now)
        PH_M1: opr_q <= bus_i;
        PH_M2: begin
          opa_q       <= bus_i;
          sel_instr_q <= (opr_q == OPR_SEL) && bus_i[0];
          io_instr_q  <= cmd_i && (opr_q == OPR_IO);
        end
        PH_X2: if (sel_instr_q) target_q <= cmd_i && (bus_i == CHIP_ID);
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n)      port_q <= '0;
    else if (!rst_n) port_q <= '0;
    else if (wr_hit) port_q <= bus_i;
  end
endmodule

// File: rtl/rom_io_node.sv
module rom_io_node
  import rom_io_pkg::*;
#(
  parameter logic [NIB_W-1:0]            CHIP_ID   = 4'd5,
  parameter logic [ROM_DEPTH*WORD_W-1:0] ROM_IMAGE = default_image()
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sync_i,
  input  logic             cmd_i,
  input  logic [NIB_W-1:0] bus_i,
  output logic [NIB_W-1:0] bus_o,
  output logic             bus_oe,
  input  logic [NIB_W-1:0] port_in,
  output logic [NIB_W-1:0] port_out,
  input  logic             port_clr_n
);
  phase_t            ph_now;
  logic [ROM_AW-1:0] word_addr;
  logic              fetch_sel;
  logic [NIB_W-1:0]  rom_nib;
  logic              rd_drive;
  logic              fetch_slot;

  rom_phase_track u_phase (
    .clk(clk), .rst_n(rst_n), .sync_i(sync_i), .ph_now(ph_now)
  );

  rom_fetch_ctl #(.CHIP_ID(CHIP_ID)) u_fetch (
    .clk(clk), .rst_n(rst_n), .ph_now(ph_now), .cmd_i(cmd_i), .bus_i(bus_i),
    .word_addr(word_addr), .sel_q(fetch_sel)
  );

  rom_word_store #(.IMAGE(ROM_IMAGE)) u_store (
    .addr(word_addr), .upper(ph_now == PH_M1), .nib(rom_nib)
  );

  rom_io_port #(.CHIP_ID(CHIP_ID)) u_port (
    .clk(clk), .rst_n(rst_n), .clr_n(port_clr_n), .ph_now(ph_now),
    .cmd_i(cmd_i), .bus_i(bus_i), .port_q(port_out), .rd_drive(rd_drive)
  );

  assign fetch_slot = fetch_sel && (ph_now == PH_M1 || ph_now == PH_M2);
  assign bus_oe     = fetch_slot || rd_drive;
  assign bus_o      = rd_drive ? port_in : rom_nib;
endmodule

// File: rtl/rom_io_node_chk.sv
module rom_io_node_chk
  import rom_io_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       port_clr_n,
  input logic       sync_i,
  input phase_t     ph_now,
  input logic       sel_q,
  input logic       bus_oe,
  input logic [3:0] port_out
);
  AST_SYNC_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    sync_i |=> (sync_i || ph_now == PH_A2)); // R1
  AST_M1_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_q && ph_now == PH_M1) |-> bus_oe); // R3
  AST_OE_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    bus_oe |-> (ph_now == PH_M1 || ph_now == PH_M2 || ph_now == PH_X2)); // R4
  AST_PORT_HOLD: assert property (@(posedge clk) disable iff (!rst_n || !port_clr_n)
    (ph_now != PH_X2) |=> $stable(port_out)); // R6
  AST_CLEAR_WINS: assert property (@(posedge clk)
    !port_clr_n |-> (port_out == 4'd0)); // R9
  AST_RESET_CLEARS: assert property (@(posedge clk)
    !rst_n |=> (port_out == 4'd0 && !bus_oe)); // R10
endmodule

bind rom_io_node rom_io_node_chk u_chk (
  .clk(clk), .rst_n(rst_n), .port_clr_n(port_clr_n), .sync_i(sync_i),
  .ph_now(ph_now), .sel_q(fetch_sel), .bus_oe(bus_oe), .port_out(port_out)
);

// File: tb/sim_rom_io_node.sv
module sim_rom_io_node;
  localparam logic [3:0] ID = 4'd5;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sync_i = 1'b0;
  logic       cmd_i = 1'b0;
  logic       port_clr_n = 1'b1;
  logic [3:0] cpu_nib = 4'd0;
  logic [3:0] port_in = 4'd0;
  logic [3:0] bus_i, bus_o, port_out;
  logic       bus_oe;

  int    errors = 0;
  int    checks = 0;
  string req = "R10 reset";
  logic  drv_rst = 1'b1;
  logic  drv_clr = 1'b1;

  // model state
  int m_ph = 0, m_lo = 0, m_mid = 0, m_opr = 0, m_opa = 0, m_port = 0;
  bit m_sel = 0, m_src = 0, m_io = 0, m_tgt = 0;

  always #2 clk = ~clk;

  assign bus_i = bus_oe ? bus_o : cpu_nib;

  rom_io_node #(.CHIP_ID(ID)) u0 (
    .clk(clk), .rst_n(rst_n), .sync_i(sync_i), .cmd_i(cmd_i), .bus_i(bus_i),
    .bus_o(bus_o), .bus_oe(bus_oe), .port_in(port_in), .port_out(port_out),
    .port_clr_n(port_clr_n)
  );

  function automatic int ref_word(int a);
    return ((a * 37) ^ 165) & 255;
  endfunction

  task automatic chk(string r, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", r, act, exp, $time);
    end
  endtask

  task automatic phase(input logic [3:0] nib, input logic cmd, input logic syn);
    int cur, e_out, eff;
    bit e_oe;
    @(negedge clk);
    cpu_nib = nib; cmd_i = cmd; sync_i = syn; rst_n = drv_rst; port_clr_n = drv_clr;
    cur = syn ? 0 : m_ph;
    if (!drv_clr) m_port = 0;
    e_oe  = (m_sel && (cur == 3 || cur == 4)) ||
            (cur == 6 && m_io && m_opa == 10 && m_tgt);
    e_out = (cur == 6 && e_oe) ? int'(port_in) :
            (cur == 3) ? (ref_word(m_mid * 16 + m_lo) >> 4) :
            (ref_word(m_mid * 16 + m_lo) & 15);
    #1;
    chk(req, int'(bus_oe), int'(e_oe));
    if (e_oe) chk(req, int'(bus_o), e_out);
    chk(req, int'(port_out), m_port);
    eff = e_oe ? e_out : int'(nib);
    @(posedge clk);
    if (!drv_rst) begin
      m_ph = 0; m_lo = 0; m_mid = 0; m_opr = 0; m_opa = 0; m_port = 0;
      m_sel = 0; m_src = 0; m_io = 0; m_tgt = 0;
    end else begin
      case (cur)
        0: m_lo = eff;
        1: m_mid = eff;
        2: m_sel = cmd && (eff == int'(ID));
        3: m_opr = eff;
        4: begin
          m_opa = eff;
          m_src = (m_opr == 2) && (eff % 2 == 1);
          m_io  = cmd && (m_opr == 14);
        end
        6: begin
          if (m_src) m_tgt = cmd && (eff == int'(ID));
          if (m_io && m_opa == 2 && m_tgt) m_port = eff;
        end
        default: ;
      endcase
      m_ph = (cur + 1) % 8;
    end
    if (!drv_clr) m_port = 0;
  endtask

  task automatic instr(input logic [11:0] a, input logic a3c, input logic [3:0] opr,
                       input logic [3:0] opa, input logic m2c, input logic [3:0] x2,
                       input logic x2c);
    phase(a[3:0], 1'b0, 1'b1);
    phase(a[7:4], 1'b0, 1'b0);
    phase(a[11:8], a3c, 1'b0);
    phase(opr, 1'b0, 1'b0);
    phase(opa, m2c, 1'b0);
    phase(4'd0, 1'b0, 1'b0);
    phase(x2, x2c, 1'b0);
    phase(4'd0, 1'b0, 1'b0);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    summary();
  end

  initial begin
    repeat (3) @(posedge clk);
    drv_rst = 1'b0;
    phase(4'd0, 1'b0, 1'b0);
    drv_rst = 1'b1;
    req = "R10 reset state";
    #1;
    chk("R10 port after reset", int'(port_out), 0);
    chk("R10 no drive after reset", int'(bus_oe), 0);

    req = "R3 fetch own word";
    instr(12'h53C, 1'b1, 4'h0, 4'h0, 1'b0, 4'h0, 1'b0);
    instr(12'h500, 1'b1, 4'h0, 4'h0, 1'b0, 4'h0, 1'b0);
    instr(12'h5FF, 1'b1, 4'h0, 4'h0, 1'b0, 4'h0, 1'b0);
    req = "R2 bank disabled at A3";
    instr(12'h512, 1'b0, 4'h3, 4'h4, 1'b0, 4'h0, 1'b0);
    req = "R4 other chip addressed";
    instr(12'h312, 1'b1, 4'h3, 4'h4, 1'b0, 4'h0, 1'b0);

    req = "R5 select this chip";
    instr(12'h100, 1'b1, 4'h2, 4'h1, 1'b0, ID, 1'b1);
    req = "R6 port write";
    instr(12'h101, 1'b1, 4'hE, 4'h2, 1'b1, 4'h9, 1'b0);
    #1 chk("R6 port loaded", int'(port_out), 9);
    req = "R7 port read";
    port_in = 4'hC;
    instr(12'h102, 1'b1, 4'hE, 4'hA, 1'b1, 4'h0, 1'b0);
    req = "R8 unknown I/O code";
    instr(12'h103, 1'b1, 4'hE, 4'h3, 1'b1, 4'h6, 1'b0);
    req = "R8 command low at M2";
    instr(12'h104, 1'b1, 4'hE, 4'h2, 1'b0, 4'h6, 1'b0);
    #1 chk("R8 port kept", int'(port_out), 9);

    req = "R5 select other chip";
    instr(12'h105, 1'b1, 4'h2, 4'h1, 1'b0, 4'h4, 1'b1);
    req = "R8 write while untargeted";
    instr(12'h106, 1'b1, 4'hE, 4'h2, 1'b1, 4'h3, 1'b0);
    #1 chk("R8 untargeted write ignored", int'(port_out), 9);
    req = "R5 select with command low";
    instr(12'h107, 1'b1, 4'h2, 4'h1, 1'b0, ID, 1'b0);
    instr(12'h108, 1'b1, 4'hE, 4'hA, 1'b1, 4'h3, 1'b0);
    req = "R5 reselect";
    instr(12'h109, 1'b1, 4'h2, 4'h3, 1'b0, ID, 1'b1);
    instr(12'h10A, 1'b1, 4'hE, 4'h2, 1'b1, 4'h4, 1'b0);
    #1 chk("R5 reselected write", int'(port_out), 4);

    req = "R9 clear during write";
    drv_clr = 1'b0;
    instr(12'h10B, 1'b1, 4'hE, 4'h2, 1'b1, 4'hF, 1'b0);
    drv_clr = 1'b1;
    #1 chk("R9 clear beats write", int'(port_out), 0);
    req = "R9 write after clear";
    instr(12'h10C, 1'b1, 4'hE, 4'h2, 1'b1, 4'h7, 1'b0);

    req = "R1 early sync";
    phase(4'h1, 1'b0, 1'b1);
    phase(4'h2, 1'b0, 1'b0);
    phase(ID, 1'b1, 1'b0);
    instr(12'h5A7, 1'b1, 4'h0, 4'h0, 1'b0, 4'h0, 1'b0);
    phase(4'h0, 1'b0, 1'b1);
    phase(4'h0, 1'b0, 1'b0);
    phase(4'h0, 1'b0, 1'b0);
    phase(4'h0, 1'b0, 1'b0);
    phase(4'h0, 1'b0, 1'b0);
    phase(4'h0, 1'b0, 1'b0);
    phase(4'h0, 1'b0, 1'b0);
    phase(4'h0, 1'b0, 1'b0);
    req = "R1 free-running wrap";
    phase(4'hE, 1'b0, 1'b0);
    phase(4'h5, 1'b0, 1'b0);
    phase(ID, 1'b1, 1'b0);
    phase(4'h0, 1'b0, 1'b0);
    phase(4'h0, 1'b0, 1'b0);

    req = "R10 mid-run reset";
    drv_rst = 1'b0;
    phase(4'h0, 1'b0, 1'b0);
    drv_rst = 1'b1;
    #1 chk("R10 port cleared", int'(port_out), 0);
    instr(12'h10D, 1'b1, 4'hE, 4'h2, 1'b1, 4'h8, 1'b0);
    #1 chk("R10 target dropped", int'(port_out), 0);
    req = "R3 fetch after reset";
    instr(12'h5C3, 1'b1, 4'h0, 4'h0, 1'b0, 4'h0, 1'b0);

    summary();
  end
endmodule